// File: doc/BRIEF.md
# Two-Source Prioritized Interrupt Service Controller

This block models how a processor works through requests from two interrupt sources. Each source raises a one-cycle request. Each source has a fixed service time: source 0 needs 3 cycles and source 1 needs 5 cycles. Source 1 has the higher priority. The controller keeps one waiting slot per source. A request that arrives while that slot is already occupied is dropped and counted. The block shows which source is in service and pulses a done strobe in the last service cycle. In that same cycle it reports the latency of the request, from its arrival to its completion.

Per-source counters record how many requests were served, how many were dropped, and the longest latency seen. A testbench or a performance study can drive the two request lines with any traffic pattern and read these figures to work out service-time statistics.

Top module: `irq_svc_ctrl`

## Requirements
- R1: A synchronous active-high reset clears service state, both waiting slots and every counter. After reset `in_service`, `svc_done`, `lat_valid` and all count and worst-latency outputs read 0. No request that was waiting before the reset is served afterwards.
- R2: When the block is idle, a request sampled in cycle c starts service in cycle c+1. `in_service` stays high for exactly the source's duration (3 cycles for source 0, 5 for source 1). `svc_done` is high only in the last of those cycles, c+3 or c+5.
- R3: When both sources request in the same cycle while the block is idle, source 1 is served first and source 0 waits.
- R4: A request that arrives while any service is running is held in its source's waiting slot. Its service starts in the cycle right after the running service's done cycle.
- R5: When a service completes and both slots are occupied, source 1 starts next, and `serv_src` reads 1 in the following cycle.
- R6: A request for a source whose waiting slot is already occupied is dropped. That source's miss count rises by one in the next cycle.
- R7: A request that arrives in the completion cycle of its own source, while that source's slot is empty, is held and served. It is not counted as missed.
- R8: In each done cycle, `lat_valid` is high and `lat_cycles` equals the done cycle minus the request's arrival cycle, for the source shown on `serv_src`. A request served at once has latency 3 for source 0 and 5 for source 1.
- R9: `worst_lat0` and `worst_lat1` hold the largest latency reported for their source since reset and never decrease.
- R10: The served count of a source rises by one in the cycle after each of its done cycles and changes at no other time.
- R11: The 16-bit miss and served counts stop at 65535 and do not wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 2 | One-cycle request per source; bit 0 is source 0, bit 1 is source 1 |
| in_service | output | 1 | High while a service runs |
| serv_src | output | 1 | Source in service (0 or 1) |
| svc_done | output | 1 | High in the last service cycle |
| lat_valid | output | 1 | Strobe qualifying `lat_cycles` |
| lat_cycles | output | 16 | Arrival-to-completion latency of the finishing request |
| served_cnt0 | output | 16 | Saturating count of completed source-0 services |
| served_cnt1 | output | 16 | Saturating count of completed source-1 services |
| miss_cnt0 | output | 16 | Saturating count of dropped source-0 requests |
| miss_cnt1 | output | 16 | Saturating count of dropped source-1 requests |
| worst_lat0 | output | 16 | Largest source-0 latency since reset |
| worst_lat1 | output | 16 | Largest source-1 latency since reset |

## Verification
A request presented in cycle c on an idle block brings `in_service` high in cycle c+1. Its done and latency strobe fall in cycle c+3 or c+5, and a waiting request's done follows its own duration after the previous done. The counters and the worst-latency registers take their new values one cycle after the done strobe. For every stimulus the driver computes the exact done cycle, source and latency and queues them. The monitor samples on the falling edge, so every result it reads was registered on the preceding rising edge. It compares each strobe against the head of that queue, including the cycle number, and reads counters only after the block has gone idle.

// File: rtl/irq_svc_pkg.sv
`timescale 1ns/1ps
package irq_svc_pkg;
  localparam int NSRC  = 2;
  localparam int SRC_W = 1;
  localparam int CNT_W = 16;
  localparam int TS_W  = 16;

  // Saturating increment of an event counter.
  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v,
                                               input logic en);
    if (en && (v != {CNT_W{1'b1}})) return v + 1'b1;
    return v;
  endfunction

  // Elapsed cycles between a time stamp and the current cycle, modulo 2^TS_W.
  function automatic logic [TS_W-1:0] span(input logic [TS_W-1:0] now_ts,
                                           input logic [TS_W-1:0] start_ts);
    return now_ts - start_ts;
  endfunction
endpackage

// File: rtl/irq_svc_arbiter.sv
`timescale 1ns/1ps
module irq_svc_arbiter
  import irq_svc_pkg::*;
(
  input  logic [NSRC-1:0]  want,
  input  logic             free,
  output logic             start,
  output logic [SRC_W-1:0] grant_src,
  output logic [NSRC-1:0]  grant
);
  // Higher index means higher priority: the last set bit wins.
  always_comb begin
    grant_src = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (want[i]) grant_src = SRC_W'(i);
    end
    start = free && (|want);
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_gnt
    assign grant[g] = start && (grant_src == SRC_W'(g));
  end
endmodule

// File: rtl/irq_svc_slot.sv
`timescale 1ns/1ps
module irq_svc_slot
  import irq_svc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic             granted,
  input  logic             fin,
  input  logic [TS_W-1:0]  now,
  input  logic [TS_W-1:0]  lat,
  output logic             want,
  output logic             pend,
  output logic             miss_ev,
  output logic [TS_W-1:0]  stamp_sel,
  output logic [CNT_W-1:0] miss_cnt,
  output logic [CNT_W-1:0] served_cnt,
  output logic [TS_W-1:0]  worst
);
  logic            pend_q;
  logic [TS_W-1:0] stamp_q;
  logic            take;

  always_comb begin
    miss_ev   = req && pend_q;
    take      = req && !pend_q;
    want      = pend_q || req;
    stamp_sel = pend_q ? stamp_q : now;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q     <= 1'b0;
      stamp_q    <= '0;
      miss_cnt   <= '0;
      served_cnt <= '0;
      worst      <= '0;
    end else begin
      if (granted) begin
        pend_q <= 1'b0;
      end else if (take) begin
        pend_q  <= 1'b1;
        stamp_q <= now;
      end
      miss_cnt   <= sat_inc(miss_cnt, miss_ev);
      served_cnt <= sat_inc(served_cnt, fin);
      if (fin && (lat > worst)) worst <= lat;
    end
  end

  assign pend = pend_q;
endmodule

// File: rtl/irq_svc_engine.sv
`timescale 1ns/1ps
module irq_svc_engine
  import irq_svc_pkg::*;
#(
  parameter int DUR0 = 3,
  parameter int DUR1 = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [SRC_W-1:0] start_src,
  input  logic [TS_W-1:0]  start_stamp,
  input  logic [TS_W-1:0]  now,
  output logic             active,
  output logic [SRC_W-1:0] src,
  output logic             done,
  output logic             free,
  output logic [TS_W-1:0]  lat
);
  localparam int DMAX  = (DUR0 > DUR1) ? DUR0 : DUR1;
  localparam int REM_W = $clog2(DMAX + 1);

  logic             act_q;
  logic [SRC_W-1:0] src_q;
  logic [REM_W-1:0] rem_q;
  logic [TS_W-1:0]  arr_q;

  function automatic logic [REM_W-1:0] dur_of(input logic [SRC_W-1:0] s);
    return (s != '0) ? REM_W'(DUR1) : REM_W'(DUR0);
  endfunction

  always_comb begin
    done = act_q && (rem_q == REM_W'(1));
    free = !act_q || done;
    lat  = span(now, arr_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= 1'b0;
      src_q <= '0;
      rem_q <= '0;
      arr_q <= '0;
    end else if (start) begin
      act_q <= 1'b1;
      src_q <= start_src;
      rem_q <= dur_of(start_src);
      arr_q <= start_stamp;
    end else if (done) begin
      act_q <= 1'b0;
      rem_q <= '0;
    end else if (act_q) begin
      rem_q <= rem_q - 1'b1;
    end
  end

  assign active = act_q;
  assign src    = src_q;
endmodule

// File: rtl/irq_svc_ctrl.sv
`timescale 1ns/1ps
module irq_svc_ctrl
  import irq_svc_pkg::*;
#(
  parameter int DUR0 = 3,
  parameter int DUR1 = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NSRC-1:0]  irq_req,
  output logic             in_service,
  output logic             serv_src,
  output logic             svc_done,
  output logic             lat_valid,
  output logic [TS_W-1:0]  lat_cycles,
  output logic [CNT_W-1:0] served_cnt0,
  output logic [CNT_W-1:0] served_cnt1,
  output logic [CNT_W-1:0] miss_cnt0,
  output logic [CNT_W-1:0] miss_cnt1,
  output logic [TS_W-1:0]  worst_lat0,
  output logic [TS_W-1:0]  worst_lat1
);
  logic [TS_W-1:0]  now_q;
  logic [NSRC-1:0]  want_vec, pend_vec, miss_vec, grant_vec, fin_vec;
  logic [TS_W-1:0]  stamp_vec [NSRC];
  logic [CNT_W-1:0] miss_arr  [NSRC];
  logic [CNT_W-1:0] serv_arr  [NSRC];
  logic [TS_W-1:0]  worst_arr [NSRC];
  logic             start, free, done, active;
  logic [SRC_W-1:0] grant_src, cur_src;
  logic [TS_W-1:0]  cur_lat;

  always_ff @(posedge clk) begin
    if (rst) now_q <= '0;
    else     now_q <= now_q + 1'b1;
  end

  irq_svc_arbiter u_arb (
    .want(want_vec), .free(free), .start(start),
    .grant_src(grant_src), .grant(grant_vec)
  );

  irq_svc_engine #(.DUR0(DUR0), .DUR1(DUR1)) u_eng (
    .clk(clk), .rst(rst), .start(start), .start_src(grant_src),
    .start_stamp(stamp_vec[grant_src]), .now(now_q),
    .active(active), .src(cur_src), .done(done), .free(free), .lat(cur_lat)
  );

  for (genvar g = 0; g < NSRC; g++) begin : g_slot
    assign fin_vec[g] = done && (cur_src == SRC_W'(g));
    irq_svc_slot u_slot (
      .clk(clk), .rst(rst), .req(irq_req[g]), .granted(grant_vec[g]),
      .fin(fin_vec[g]), .now(now_q), .lat(cur_lat),
      .want(want_vec[g]), .pend(pend_vec[g]), .miss_ev(miss_vec[g]),
      .stamp_sel(stamp_vec[g]), .miss_cnt(miss_arr[g]),
      .served_cnt(serv_arr[g]), .worst(worst_arr[g])
    );
  end

  assign in_service  = active;
  assign serv_src    = cur_src[0];
  assign svc_done    = done;
  assign lat_valid   = done;
  assign lat_cycles  = cur_lat;
  assign served_cnt0 = serv_arr[0];
  assign served_cnt1 = serv_arr[1];
  assign miss_cnt0   = miss_arr[0];
  assign miss_cnt1   = miss_arr[1];
  assign worst_lat0  = worst_arr[0];
  assign worst_lat1  = worst_arr[1];
endmodule

// File: rtl/irq_svc_chk.sv
`timescale 1ns/1ps
module irq_svc_chk #(
  parameter int DUR0 = 3,
  parameter int DUR1 = 5
) (
  input logic        clk,
  input logic        rst,
  input logic [1:0]  irq_req,
  input logic        in_service,
  input logic        serv_src,
  input logic        svc_done,
  input logic        lat_valid,
  input logic [15:0] lat_cycles,
  input logic [15:0] miss_cnt0,
  input logic [15:0] served_cnt0,
  input logic [15:0] served_cnt1,
  input logic [15:0] worst_lat0,
  input logic [15:0] worst_lat1,
  input logic [1:0]  pend,
  input logic [1:0]  miss_ev
);
  // R2
  done_in_service_chk: assert property (@(posedge clk) disable iff (rst)
    svc_done |-> in_service);

  // R2
  idle_start_chk: assert property (@(posedge clk) disable iff (rst)
    (!in_service && (|irq_req)) |=> in_service);

  // R3
  tie_priority_chk: assert property (@(posedge clk) disable iff (rst)
    (!in_service && (&irq_req)) |=> serv_src);

  // R5
  pend_priority_chk: assert property (@(posedge clk) disable iff (rst)
    (svc_done && pend[1]) |=> (in_service && serv_src));

  // R8
  lat_floor_chk: assert property (@(posedge clk) disable iff (rst)
    lat_valid |-> (lat_cycles >= (serv_src ? 16'(DUR1) : 16'(DUR0))));

  // R6
  miss_count_chk: assert property (@(posedge clk) disable iff (rst)
    miss_ev[0] |=> ((miss_cnt0 == $past(miss_cnt0) + 16'd1) ||
                    ($past(miss_cnt0) == 16'hFFFF)));

  // R9
  worst_mono_chk: assert property (@(posedge clk) disable iff (rst)
    in_service |=> ((worst_lat0 >= $past(worst_lat0)) &&
                    (worst_lat1 >= $past(worst_lat1))));

  // R10
  served_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !svc_done |=> ($stable(served_cnt0) && $stable(served_cnt1)));
endmodule

bind irq_svc_ctrl irq_svc_chk #(.DUR0(DUR0), .DUR1(DUR1)) u_chk (
  .clk(clk), .rst(rst), .irq_req(irq_req), .in_service(in_service),
  .serv_src(serv_src), .svc_done(svc_done), .lat_valid(lat_valid),
  .lat_cycles(lat_cycles), .miss_cnt0(miss_cnt0), .served_cnt0(served_cnt0),
  .served_cnt1(served_cnt1), .worst_lat0(worst_lat0), .worst_lat1(worst_lat1),
  .pend(pend_vec), .miss_ev(miss_vec)
);

// File: tb/tb_irq_svc_ctrl.sv
`timescale 1ns/1ps
module tb_irq_svc_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  irq_req = 2'b00;
  logic        in_service, serv_src, svc_done, lat_valid;
  logic [15:0] lat_cycles, served_cnt0, served_cnt1, miss_cnt0, miss_cnt1;
  logic [15:0] worst_lat0, worst_lat1;

  irq_svc_ctrl dut (
    .clk(clk), .rst(rst), .irq_req(irq_req), .in_service(in_service),
    .serv_src(serv_src), .svc_done(svc_done), .lat_valid(lat_valid),
    .lat_cycles(lat_cycles), .served_cnt0(served_cnt0), .served_cnt1(served_cnt1),
    .miss_cnt0(miss_cnt0), .miss_cnt1(miss_cnt1),
    .worst_lat0(worst_lat0), .worst_lat1(worst_lat1)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_err = 0;
  bit sb_on = 1'b0;
  bit finished = 1'b0;

  typedef struct { int src; int lat; int at; } exp_t;
  exp_t sbq[$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic push(input int s, input int l, input int t);
    exp_t e;
    e.src = s; e.lat = l; e.at = t;
    sbq.push_back(e);
  endtask

  // Drive one request cycle; caller is at a falling edge.
  task automatic fire(input logic [1:0] r, output int at);
    irq_req = r;
    at = cyc;
    @(negedge clk);
    irq_req = 2'b00;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: compare every latency strobe against the scoreboard head.
  always @(negedge clk) begin
    if (!rst && sb_on && lat_valid) begin
      if (sbq.size() == 0) begin
        check(1'b0, "R8 unexpected done", int'(lat_cycles), -1);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        check(int'(serv_src) == e.src, "R3/R5 done source", int'(serv_src), e.src);
        check(int'(lat_cycles) == e.lat, "R8 latency", int'(lat_cycles), e.lat);
        check(cyc == e.at, "R2/R4 done cycle", cyc, e.at);
      end
    end
  end

  initial begin
    #1_500_000;
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int c, t;
    idle(3);
    rst = 1'b0;
    // R1 reset state
    check(!in_service && !svc_done && !lat_valid, "R1 idle after reset", int'(in_service), 0);
    check(served_cnt0 == 0 && served_cnt1 == 0 && miss_cnt0 == 0 && miss_cnt1 == 0,
          "R1 counts after reset", int'(served_cnt0 + served_cnt1 + miss_cnt0 + miss_cnt1), 0);
    check(worst_lat0 == 0 && worst_lat1 == 0, "R1 worst after reset", int'(worst_lat0 + worst_lat1), 0);
    sb_on = 1'b1;

    // R2 single source 0
    fire(2'b01, c); push(0, 3, c + 3);
    check(in_service && !serv_src, "R2 start next cycle", int'(in_service), 1);
    idle(12);
    // R2 single source 1
    fire(2'b10, c); push(1, 5, c + 5);
    idle(12);
    // R3 simultaneous
    fire(2'b11, c); push(1, 5, c + 5); push(0, 8, c + 8);
    idle(14);
    // R4 arrival during service
    fire(2'b01, c); push(0, 3, c + 3); push(1, 7, c + 8);
    fire(2'b10, t);
    idle(14);
    // R5 both waiting, R6 repeat while waiting
    fire(2'b01, c); push(0, 3, c + 3); push(1, 6, c + 8); push(0, 10, c + 11);
    fire(2'b01, t);
    fire(2'b11, t);
    idle(16);
    check(miss_cnt0 == 1, "R6 miss counted", int'(miss_cnt0), 1);
    // R7 request in own completion cycle
    fire(2'b01, c); push(0, 3, c + 3); push(0, 3, c + 6);
    idle(2);
    fire(2'b01, t);
    check(t == c + 3, "R7 stimulus timing", t, c + 3);
    idle(12);
    check(miss_cnt0 == 1, "R7 no extra miss", int'(miss_cnt0), 1);

    check(sbq.size() == 0, "R8 all completions seen", sbq.size(), 0);
    check(served_cnt0 == 7, "R10 served source 0", int'(served_cnt0), 7);
    check(served_cnt1 == 4, "R10 served source 1", int'(served_cnt1), 4);
    check(miss_cnt1 == 0, "R6 no source-1 miss", int'(miss_cnt1), 0);
    check(worst_lat0 == 10, "R9 worst source 0", int'(worst_lat0), 10);
    check(worst_lat1 == 7, "R9 worst source 1", int'(worst_lat1), 7);

    // R1 reset during activity discards everything
    fire(2'b11, c);
    fire(2'b01, t);
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    check(!in_service, "R1 no service after reset", int'(in_service), 0);
    check(served_cnt0 == 0 && worst_lat0 == 0 && miss_cnt0 == 0, "R1 counters cleared",
          int'(served_cnt0 + worst_lat0 + miss_cnt0), 0);
    idle(10);
    check(!in_service && sbq.size() == 0, "R1 waiting request dropped", int'(in_service), 0);

    // R11 saturation under continuous source-1 requests
    sb_on = 1'b0;
    irq_req = 2'b10;
    repeat (90000) @(negedge clk);
    irq_req = 2'b00;
    idle(20);
    check(miss_cnt1 == 16'hFFFF, "R11 miss saturates", int'(miss_cnt1), 65535);
    check(worst_lat1 == 9, "R9 worst under load", int'(worst_lat1), 9);
    check(served_cnt1 != 0 && served_cnt1 != 16'hFFFF, "R10 served under load", int'(served_cnt1), 18000);
    check(miss_cnt0 == 0 && served_cnt0 == 0, "R6 source 0 untouched", int'(miss_cnt0 + served_cnt0), 0);

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule